// File: doc/BRIEF.md
# Bus Target Transfer Policy Controller

This block decides how a bus target answers each incoming read or write transaction. An 8-bit policy register holds one bit for each rule. A request arrives with a command code and a flag that shows whether the outbound master-side write buffers still hold data. One clock later the block returns a single response word. It either accepts or retries the cycle, and it also says:
- whether the target must disconnect together with the first data phase;
- whether a full cache line is to be fetched;
- whether the internal bus may burst;
- whether write data goes into the target's own write buffers.

Software writes the policy register through a simple write strobe and reads it back on a parallel output. The register leaves reset at zero. In that state the target:
- takes multi-phase transfers;
- accepts cycles even when the master buffers are busy;
- keeps its write buffers off;
- reads a single item for plain reads;
- never bursts.

Top module: `tgtPolicyTop`

## Requirements
- R1: After reset the policy register reads 00h, and no response is presented (`rspValid` low) until a request is made.
- R2: A register write stores bits 6..1 of `cfgWrData`. Bits 7 and 0 always read back as zero.
- R3: If policy bit 4 (retry-on-busy) is set and `mstBufBusy` is high, a legal request is answered with `rspRetry`=1. `rspAccept`, `rspDisc`, `rspBurst`, `rspLineRd` and `rspPost` are then all 0.
- R4: If bit 4 is clear, a legal request is accepted (`rspAccept`=1, `rspRetry`=0) whatever the value of `mstBufBusy`.
- R5: Command codes are: read=0, write=1, memory-read-line=2, read-multiple=3, write-and-invalidate=4. Codes 1 and 4 are writes. For an accepted write, `rspDisc` equals policy bit 6 (single-write mode).
- R6: For an accepted read (codes 0, 2, 3), `rspDisc` equals policy bit 5 (single-read mode).
- R7: For an accepted read, `rspLineRd` is 1 when policy bit 2 is set or the command is code 2 or 3. For a plain read with bit 2 clear, it is 0. For writes it is always 0.
- R8: `rspBurst` is 1 only for an accepted write-and-invalidate (code 4) while policy bit 1 is set. Bit 1 never causes a burst on any other command, reads included.
- R9: `rspPost` is 1 for an accepted write (codes 1, 4) exactly when policy bit 3 (target write buffer enable) is set. It is 0 for reads.
- R10: Every response is registered. It appears in the clock cycle after the one in which `reqValid` was sampled high, and `rspValid` is high for that single cycle.
- R11: Command codes 5 to 7 are ignored. They produce no response: `rspValid` and all response flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Policy register write strobe |
| cfgWrData | input | 8 | Policy register write value |
| cfgRdData | output | 8 | Policy register read-back |
| reqValid | input | 1 | Transaction request present |
| reqCmd | input | 3 | Transaction command code |
| mstBufBusy | input | 1 | Master-side write buffers hold data |
| rspValid | output | 1 | Response word valid |
| rspAccept | output | 1 | Cycle accepted |
| rspRetry | output | 1 | Cycle retried |
| rspDisc | output | 1 | Disconnect with the first data phase |
| rspBurst | output | 1 | Internal bus burst permitted |
| rspLineRd | output | 1 | Fetch a full cache line |
| rspPost | output | 1 | Write data goes to the target write buffers |

## Verification
The hardest case to reach is a policy bit whose effect is hidden by another rule. Examples are single-write mode on a retried cycle, and the burst bit on a read, where the bit must do nothing. The bench steps through every combination of policy bits 6..1, every command code and both buffer states. It rewrites the register before each request. The expected response word is worked out from the rules, so each masking case is reached directly.

// File: rtl/tgtPolicyPkg.sv
package tgtPolicyPkg;
  localparam int REG_W = 8;
  localparam int CMD_W = 3;

  localparam int BIT_SGL_WR  = 6;
  localparam int BIT_SGL_RD  = 5;
  localparam int BIT_RETRY   = 4;
  localparam int BIT_WBUF_EN = 3;
  localparam int BIT_LINE_RD = 2;
  localparam int BIT_BURST   = 1;

  localparam logic [REG_W-1:0] WRITABLE_MASK =
    REG_W'((1 << BIT_SGL_WR) | (1 << BIT_SGL_RD) | (1 << BIT_RETRY) |
           (1 << BIT_WBUF_EN) | (1 << BIT_LINE_RD) | (1 << BIT_BURST));

  typedef enum logic [CMD_W-1:0] {
    CMD_READ    = 3'd0,
    CMD_WRITE   = 3'd1,
    CMD_RD_LINE = 3'd2,
    CMD_RD_MULT = 3'd3,
    CMD_WR_INV  = 3'd4
  } tgtCmd_e;

  typedef struct packed {
    logic fire;
    logic accept;
    logic retry;
    logic disc;
    logic burst;
    logic lineRd;
    logic post;
  } tgtStrobe_t;
endpackage

// File: rtl/tgtPolicyCtrl.sv
module tgtPolicyCtrl
  import tgtPolicyPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  output logic [REG_W-1:0] cfgRdData,
  input  logic             reqValid,
  input  logic [CMD_W-1:0] reqCmd,
  input  logic             mstBufBusy,
  output tgtStrobe_t       strobe
);
  logic [REG_W-1:0] policyReg;
  logic isRead, isWrite, isLegal, doRetry, doAccept;

  always_ff @(posedge clk) begin
    if (!rstN) policyReg <= '0;
    else if (cfgWrEn) policyReg <= cfgWrData & WRITABLE_MASK;
  end

  assign cfgRdData = policyReg;

  always_comb begin
    isRead  = (reqCmd == CMD_READ) || (reqCmd == CMD_RD_LINE) || (reqCmd == CMD_RD_MULT);
    isWrite = (reqCmd == CMD_WRITE) || (reqCmd == CMD_WR_INV);
    isLegal = reqValid && (isRead || isWrite);
    doRetry  = isLegal && policyReg[BIT_RETRY] && mstBufBusy;
    doAccept = isLegal && !doRetry;

    strobe.fire   = isLegal;
    strobe.accept = doAccept;
    strobe.retry  = doRetry;
    strobe.disc   = doAccept && ((isWrite && policyReg[BIT_SGL_WR]) ||
                                 (isRead  && policyReg[BIT_SGL_RD]));
    strobe.burst  = doAccept && (reqCmd == CMD_WR_INV) && policyReg[BIT_BURST];
    strobe.lineRd = doAccept && isRead &&
                    (policyReg[BIT_LINE_RD] || reqCmd == CMD_RD_LINE || reqCmd == CMD_RD_MULT);
    strobe.post   = doAccept && isWrite && policyReg[BIT_WBUF_EN];
  end

  // R2: writable field follows the written value one cycle later
  assert_cfg_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData[6:1] == $past(cfgWrData[6:1]));
  // R2: reserved bits stay clear after any write
  assert_cfg_rsvd_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgRdData[7] == 1'b0 && cfgRdData[0] == 1'b0));
  // R2: register holds without a write strobe
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(cfgRdData));
endmodule

// File: rtl/tgtPolicyDp.sv
module tgtPolicyDp
  import tgtPolicyPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       mstBufBusy,
  input  logic [REG_W-1:0] cfgRdData,
  input  tgtStrobe_t strobe,
  output logic       rspValid,
  output logic       rspAccept,
  output logic       rspRetry,
  output logic       rspDisc,
  output logic       rspBurst,
  output logic       rspLineRd,
  output logic       rspPost
);
  tgtStrobe_t rspQ;

  always_ff @(posedge clk) begin
    if (!rstN) rspQ <= '0;
    else       rspQ <= strobe;
  end

  assign rspValid  = rspQ.fire;
  assign rspAccept = rspQ.accept;
  assign rspRetry  = rspQ.retry;
  assign rspDisc   = rspQ.disc;
  assign rspBurst  = rspQ.burst;
  assign rspLineRd = rspQ.lineRd;
  assign rspPost   = rspQ.post;

  // R10: a response only follows a request sampled one cycle earlier
  assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid));
  // R3 / R4: a valid response is exactly one of accept or retry
  assert_one_answer_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot({rspAccept, rspRetry}));
  // R11: no flag without a valid response
  assert_no_stray_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> ({rspAccept, rspRetry, rspDisc, rspBurst, rspLineRd, rspPost} == '0));
  // R3: retry only when retry-on-busy was set and buffers were busy
  assert_retry_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspRetry |-> ($past(mstBufBusy) && $past(cfgRdData[BIT_RETRY])));
  // R3: retried cycles carry no other permission
  assert_retry_clean_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspRetry |-> !(rspDisc || rspBurst || rspLineRd || rspPost));
  // R8: burst only with the burst bit set
  assert_burst_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspBurst |-> $past(cfgRdData[BIT_BURST]));
  // R7 / R9: line fetch and write posting never coincide
  assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(rspLineRd && rspPost));
endmodule

// File: rtl/tgtPolicyTop.sv
module tgtPolicyTop
  import tgtPolicyPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic [7:0] cfgRdData,
  input  logic       reqValid,
  input  logic [2:0] reqCmd,
  input  logic       mstBufBusy,
  output logic       rspValid,
  output logic       rspAccept,
  output logic       rspRetry,
  output logic       rspDisc,
  output logic       rspBurst,
  output logic       rspLineRd,
  output logic       rspPost
);
  tgtStrobe_t strobe;

  tgtPolicyCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqCmd(reqCmd),
    .mstBufBusy(mstBufBusy), .strobe(strobe)
  );

  tgtPolicyDp uDp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mstBufBusy(mstBufBusy),
    .cfgRdData(cfgRdData), .strobe(strobe),
    .rspValid(rspValid), .rspAccept(rspAccept), .rspRetry(rspRetry),
    .rspDisc(rspDisc), .rspBurst(rspBurst), .rspLineRd(rspLineRd),
    .rspPost(rspPost)
  );
endmodule

// File: tb/sim_tgtPolicyTop.sv
`timescale 1ns/1ps
module sim_tgtPolicyTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic reqValid = 1'b0;
  logic [2:0] reqCmd = '0;
  logic mstBufBusy = 1'b0;
  logic rspValid, rspAccept, rspRetry, rspDisc, rspBurst, rspLineRd, rspPost;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tgtPolicyTop u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqCmd(reqCmd),
    .mstBufBusy(mstBufBusy), .rspValid(rspValid), .rspAccept(rspAccept),
    .rspRetry(rspRetry), .rspDisc(rspDisc), .rspBurst(rspBurst),
    .rspLineRd(rspLineRd), .rspPost(rspPost)
  );

  function automatic logic [6:0] rspWord();
    return {rspValid, rspAccept, rspRetry, rspDisc, rspBurst, rspLineRd, rspPost};
  endfunction

  // expected {valid,accept,retry,disc,burst,line,post}
  function automatic logic [6:0] model(input logic [7:0] pol, input int cmd, input logic busy);
    logic rd, wr, acc, rty;
    rd = (cmd == 0) || (cmd == 2) || (cmd == 3);
    wr = (cmd == 1) || (cmd == 4);
    if (!(rd || wr)) return 7'd0;              // R11
    rty = pol[4] && busy;                       // R3
    acc = !rty;                                 // R4
    return {1'b1, acc, rty,
            acc && ((wr && pol[6]) || (rd && pol[5])),          // R5 R6
            acc && (cmd == 4) && pol[1],                        // R8
            acc && rd && (pol[2] || cmd == 2 || cmd == 3),      // R7
            acc && wr && pol[3]};                               // R9
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset register", cfgRdData, 8'h00);
    check("R1 idle response", {1'b0, rspWord()}, 8'h00);

    // R2: reserved bits masked, others stored
    writeCfg(8'hFF);
    check("R2 all ones", cfgRdData, 8'h7E);
    writeCfg(8'h81);
    check("R2 reserved only", cfgRdData, 8'h00);
    writeCfg(8'h2A);
    check("R2 pattern", cfgRdData, 8'h2A);

    // R1: reset-state policy behaviour
    writeCfg(8'h00);
    for (int cmd = 0; cmd < 8; cmd++) begin
      @(negedge clk);
      reqValid = 1'b1; reqCmd = 3'(cmd); mstBufBusy = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      check($sformatf("R1 default policy cmd=%0d", cmd), {1'b0, rspWord()},
            {1'b0, model(8'h00, cmd, 1'b1)});
    end

    // exhaustive sweep R3..R11
    for (int p = 0; p < 64; p++) begin
      for (int cmd = 0; cmd < 8; cmd++) begin
        for (int b = 0; b < 2; b++) begin
          logic [7:0] pol;
          pol = 8'(p << 1);
          writeCfg(pol | 8'h81);
          @(negedge clk);
          reqValid = 1'b1; reqCmd = 3'(cmd); mstBufBusy = 1'(b);
          @(negedge clk);
          reqValid = 1'b0;
          check($sformatf("R3-R9 R10 R11 pol=%02h cmd=%0d busy=%0d", pol, cmd, b),
                {1'b0, rspWord()}, {1'b0, model(pol, cmd, 1'(b))});
          @(negedge clk);
          check("R10 single-cycle response", {1'b0, rspWord()}, 8'h00);
        end
      end
    end

    // R10: back-to-back requests, each answered next cycle
    writeCfg(8'h40);
    @(negedge clk);
    reqValid = 1'b1; reqCmd = 3'd1; mstBufBusy = 1'b0;
    @(negedge clk);
    reqCmd = 3'd0;
    check("R10 back-to-back first", {1'b0, rspWord()}, {1'b0, model(8'h40, 1, 1'b0)});
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 back-to-back second", {1'b0, rspWord()}, {1'b0, model(8'h40, 0, 1'b0)});

    finished = 1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule